// File: doc/BRIEF.md
# Pipelined Control Signal Chain

This block produces the control word for every instruction of a five-stage in-order pipeline and moves it through the execute, memory and writeback stages. The opcode and function fields are captured into the fetch/decode register. A single decoder reads them there and builds one control word. The word is split into three groups, and each group travels with its instruction. Each stage therefore sees only the bits of the instruction it holds. The execute group reaches the outputs one cycle after decode, the memory group two cycles after, and the writeback group three cycles after.

Two hazard inputs shape the flow. A stall keeps the fetch/decode register unchanged and sends an all-zero bubble into execute. A flush squashes the instruction in fetch/decode and the one leaving decode, so that neither can write a register or memory. Older instructions keep draining. The datapath is not part of this block.

Top module: `ctl_pipe`

## Requirements
- R1: While rst_ni is low, every control output is 0. The all-zero word is the bubble: no register write, no memory write, no branch, and ALU operation code 0 (add).
- R2: An R-type instruction (opcode 6'h00) with function 6'h20/6'h22/6'h24/6'h25/6'h2A gives reg_dst=1, alu_src=0, ext_op=0, ALU op 0/1/2/3/4 (add/sub/and/or/slt), mem_wr=0, branch=0, mem_to_reg=0, reg_wr=1.
- R3: A load (opcode 6'h23) gives reg_dst=0, alu_src=1, ext_op=1, ALU op 0, mem_wr=0, branch=0, mem_to_reg=1, reg_wr=1. No stage ever shows mem_to_reg=1 with reg_wr=0.
- R4: A store (opcode 6'h2B) gives alu_src=1, ext_op=1, ALU op 0, mem_wr=1, and every other bit 0. A branch-equal (opcode 6'h04) gives ext_op=1, ALU op 1, branch=1, and every other bit 0. No instruction has both mem_wr and reg_wr set.
- R5: Any other opcode, or an R-type instruction with any other function code, decodes to the bubble.
- R6: Fields sampled at clock edge n appear on the execute outputs after edge n+1, on the memory outputs after edge n+2, and on the writeback outputs after edge n+3. Each group is the same instruction's bits moved down one stage per cycle.
- R7: With stall_i high and flush_i low, the fetch/decode register keeps its contents, the execute stage receives a bubble, and opcode_i/funct_i are ignored. The held instruction enters execute in the first cycle without a stall.
- R8: With flush_i high, the execute stage receives a bubble and fetch/decode is emptied, whatever stall_i is. The instruction that was in execute still moves on to memory and writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| opcode_i | input | 6 | opcode field of the fetched instruction |
| funct_i | input | 6 | function field of the fetched instruction |
| stall_i | input | 1 | hold fetch/decode, insert a bubble into execute |
| flush_i | input | 1 | squash the fetch/decode and decode instructions |
| ex_reg_dst_o | output | 1 | destination selects rd field |
| ex_alu_src_o | output | 1 | ALU second operand is the immediate |
| ex_ext_op_o | output | 1 | sign-extend the immediate |
| ex_alu_op_o | output | 3 | ALU operation code |
| mem_wr_o | output | 1 | memory write enable |
| mem_branch_o | output | 1 | branch-equal in the memory stage |
| wb_mem_to_reg_o | output | 1 | write back load data rather than the ALU result |
| wb_reg_wr_o | output | 1 | register file write enable |

## Verification
The bench uses the default parameters: 6-bit opcode and function fields, which give the 3-bit ALU code. This covers every legal encoding and a spread of illegal ones. A random mix of stalls, flushes and both together reaches back-to-back hazards at every stage boundary. Directed sequences pin down the exact output cycle of each group and the priority of flush over stall.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  parameter int unsigned OPC_W = 6;
  parameter int unsigned FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2, ALU_OR = 3'd3, ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    ext_op;
    alu_op_e alu_op;
  } ex_ctl_t;

  typedef struct packed {
    logic mem_wr;
    logic branch;
  } mem_ctl_t;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_wr;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } stage_ctl_t;

  localparam int unsigned CTL_W   = $bits(stage_ctl_t);
  localparam int unsigned LATE_W  = $bits(mem_ctl_t) + $bits(wb_ctl_t);
  localparam int unsigned WB_W    = $bits(wb_ctl_t);
  localparam int unsigned IFID_W  = OPC_W + FN_W + 1;
endpackage

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // clear outranks enable; cleared value is the bubble (all zero)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (en_i)   q_o <= d_i;
  end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  output stage_ctl_t       ctl_o
);
  always_comb begin
    ctl_o = '0;
    if (valid_i) begin
      unique case (opcode_i)
        OPC_RTYPE: begin
          ctl_o.ex.reg_dst = 1'b1;
          ctl_o.wb.reg_wr  = 1'b1;
          unique case (funct_i)
            FN_ADD:  ctl_o.ex.alu_op = ALU_ADD;
            FN_SUB:  ctl_o.ex.alu_op = ALU_SUB;
            FN_AND:  ctl_o.ex.alu_op = ALU_AND;
            FN_OR:   ctl_o.ex.alu_op = ALU_OR;
            FN_SLT:  ctl_o.ex.alu_op = ALU_SLT;
            default: ctl_o = '0;
          endcase
        end
        OPC_LOAD: begin
          ctl_o.ex.alu_src    = 1'b1;
          ctl_o.ex.ext_op     = 1'b1;
          ctl_o.wb.mem_to_reg = 1'b1;
          ctl_o.wb.reg_wr     = 1'b1;
        end
        OPC_STORE: begin
          ctl_o.ex.alu_src = 1'b1;
          ctl_o.ex.ext_op  = 1'b1;
          ctl_o.mem.mem_wr = 1'b1;
        end
        OPC_BEQ: begin
          ctl_o.ex.ext_op  = 1'b1;
          ctl_o.ex.alu_op  = ALU_SUB;
          ctl_o.mem.branch = 1'b1;
        end
        default: ctl_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ctl_pipe.sv
module ctl_pipe
  import ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  input  logic             stall_i,
  input  logic             flush_i,
  output logic             ex_reg_dst_o,
  output logic             ex_alu_src_o,
  output logic             ex_ext_op_o,
  output logic [2:0]       ex_alu_op_o,
  output logic             mem_wr_o,
  output logic             mem_branch_o,
  output logic             wb_mem_to_reg_o,
  output logic             wb_reg_wr_o
);
  logic [IFID_W-1:0] if_id_q;
  stage_ctl_t        dec_ctl;
  stage_ctl_t        id_ex_q;
  logic [LATE_W-1:0] ex_mem_q;
  logic [WB_W-1:0]   mem_wb_q;
  mem_ctl_t          mem_grp;
  wb_ctl_t           wb_grp;

  ctl_stage_reg #(.W(IFID_W)) u_if_id (
    .clk_i, .rst_ni,
    .en_i (!stall_i),
    .clr_i(flush_i),
    .d_i  ({1'b1, opcode_i, funct_i}),
    .q_o  (if_id_q)
  );

  ctl_decoder u_dec (
    .valid_i (if_id_q[IFID_W-1]),
    .opcode_i(if_id_q[FN_W +: OPC_W]),
    .funct_i (if_id_q[FN_W-1:0]),
    .ctl_o   (dec_ctl)
  );

  ctl_stage_reg #(.W(CTL_W)) u_id_ex (
    .clk_i, .rst_ni,
    .en_i (1'b1),
    .clr_i(stall_i | flush_i),
    .d_i  (dec_ctl),
    .q_o  (id_ex_q)
  );

  ctl_stage_reg #(.W(LATE_W)) u_ex_mem (
    .clk_i, .rst_ni,
    .en_i (1'b1),
    .clr_i(1'b0),
    .d_i  ({id_ex_q.mem, id_ex_q.wb}),
    .q_o  (ex_mem_q)
  );

  ctl_stage_reg #(.W(WB_W)) u_mem_wb (
    .clk_i, .rst_ni,
    .en_i (1'b1),
    .clr_i(1'b0),
    .d_i  (ex_mem_q[WB_W-1:0]),
    .q_o  (mem_wb_q)
  );

  assign mem_grp = mem_ctl_t'(ex_mem_q[LATE_W-1:WB_W]);
  assign wb_grp  = wb_ctl_t'(mem_wb_q);

  assign ex_reg_dst_o    = id_ex_q.ex.reg_dst;
  assign ex_alu_src_o    = id_ex_q.ex.alu_src;
  assign ex_ext_op_o     = id_ex_q.ex.ext_op;
  assign ex_alu_op_o     = id_ex_q.ex.alu_op;
  assign mem_wr_o        = mem_grp.mem_wr;
  assign mem_branch_o    = mem_grp.branch;
  assign wb_mem_to_reg_o = wb_grp.mem_to_reg;
  assign wb_reg_wr_o     = wb_grp.reg_wr;
endmodule

// File: rtl/ctl_pipe_chk.sv
module ctl_pipe_chk
  import ctl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic              flush_i,
  input logic [IFID_W-1:0] if_id,
  input stage_ctl_t        id_ex,
  input logic [LATE_W-1:0] ex_mem,
  input logic [WB_W-1:0]   mem_wb
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_bubble_R1: assert (id_ex == '0 && ex_mem == '0 && mem_wb == '0);
    end
  end

  assert_load_wb_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wb[1] |-> mem_wb[0]);

  assert_no_store_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_mem[3] |-> !ex_mem[0]);

  assert_mem_follows_ex_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ex_mem == $past({id_ex.mem, id_ex.wb}));

  assert_wb_follows_mem_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> mem_wb == $past(ex_mem[WB_W-1:0]));

  assert_stall_bubble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush_i) |=> id_ex == '0);

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush_i) |=> $stable(if_id));

  assert_flush_squash_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (id_ex == '0 && !if_id[IFID_W-1]));
endmodule

bind ctl_pipe ctl_pipe_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .stall_i(stall_i),
  .flush_i(flush_i),
  .if_id  (if_id_q),
  .id_ex  (id_ex_q),
  .ex_mem (ex_mem_q),
  .mem_wb (mem_wb_q)
);

// File: tb/ctl_pipe_tb.sv
module ctl_pipe_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [5:0] opcode_i = 6'h3F;
  logic [5:0] funct_i = 6'h00;
  logic       stall_i = 1'b0;
  logic       flush_i = 1'b0;
  logic       ex_reg_dst_o, ex_alu_src_o, ex_ext_op_o;
  logic [2:0] ex_alu_op_o;
  logic       mem_wr_o, mem_branch_o, wb_mem_to_reg_o, wb_reg_wr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference pipeline state
  bit       m_v;
  bit [5:0] m_op, m_fn;
  bit [9:0] m_idex;
  bit [3:0] m_exmem;
  bit [1:0] m_memwb;

  always #2 clk_i = ~clk_i;

  ctl_pipe u_dut (.*);

  // bit order: reg_dst alu_src ext_op alu_op[2:0] mem_wr branch mem_to_reg reg_wr
  function automatic bit [9:0] ref_dec(bit v, bit [5:0] op, bit [5:0] fn);
    if (!v) return '0;
    case (op)
      6'h00: case (fn)
        6'h20: return 10'b1_0_0_000_00_01;
        6'h22: return 10'b1_0_0_001_00_01;
        6'h24: return 10'b1_0_0_010_00_01;
        6'h25: return 10'b1_0_0_011_00_01;
        6'h2A: return 10'b1_0_0_100_00_01;
        default: return '0;
      endcase
      6'h23: return 10'b0_1_1_000_00_11;
      6'h2B: return 10'b0_1_1_000_10_00;
      6'h04: return 10'b0_0_1_001_01_00;
      default: return '0;
    endcase
  endfunction

  function automatic bit [9:0] outs();
    return {ex_reg_dst_o, ex_alu_src_o, ex_ext_op_o, ex_alu_op_o,
            mem_wr_o, mem_branch_o, wb_mem_to_reg_o, wb_reg_wr_o};
  endfunction

  task automatic check(string tag, bit [9:0] got, bit [9:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(bit [5:0] op, bit [5:0] fn, bit st, bit fl);
    opcode_i = op; funct_i = fn; stall_i = st; flush_i = fl;
  endtask

  // one clock: model advances with the same inputs, outputs sampled 1 ns later
  task automatic step();
    @(posedge clk_i);
    m_memwb = m_exmem[1:0];
    m_exmem = m_idex[3:0];
    if (flush_i) begin
      m_idex = '0; m_v = 1'b0;
    end else if (stall_i) begin
      m_idex = '0;
    end else begin
      m_idex = ref_dec(m_v, m_op, m_fn);
      m_v = 1'b1; m_op = opcode_i; m_fn = funct_i;
    end
    #1;
  endtask

  function automatic bit [9:0] model_out();
    return {m_idex[9:4], m_exmem[3:2], m_memwb[1:0]};
  endfunction

  // single instruction followed by illegal filler; checks each group at its stage
  task automatic run_one(string tag, bit [5:0] op, bit [5:0] fn, bit [9:0] exp);
    bit [9:0] o;
    drive(op, fn, 0, 0); step();
    drive(6'h3F, 6'h00, 0, 0); step();
    o = outs(); check({tag, " ex"}, {o[9:4], 4'b0}, {exp[9:4], 4'b0});
    step();
    o = outs(); check({tag, " mem"}, {6'b0, o[3:2], 2'b0}, {6'b0, exp[3:2], 2'b0});
    step();
    o = outs(); check({tag, " wb"}, {8'b0, o[1:0]}, {8'b0, exp[1:0]});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [9:0] o;
    void'($urandom(32'd2024));
    m_v = 0; m_op = 0; m_fn = 0; m_idex = 0; m_exmem = 0; m_memwb = 0;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 check("R1 reset bubble", outs(), 10'b0);
    rst_ni = 1'b1;

    // R2 R-type variants
    run_one("R2 add", 6'h00, 6'h20, 10'b1_0_0_000_00_01);
    run_one("R2 sub", 6'h00, 6'h22, 10'b1_0_0_001_00_01);
    run_one("R2 and", 6'h00, 6'h24, 10'b1_0_0_010_00_01);
    run_one("R2 or",  6'h00, 6'h25, 10'b1_0_0_011_00_01);
    run_one("R2 slt", 6'h00, 6'h2A, 10'b1_0_0_100_00_01);
    // R3 load, R4 store/branch, R5 illegal
    run_one("R3 load",  6'h23, 6'h15, 10'b0_1_1_000_00_11);
    run_one("R4 store", 6'h2B, 6'h00, 10'b0_1_1_000_10_00);
    run_one("R4 beq",   6'h04, 6'h3F, 10'b0_0_1_001_01_00);
    run_one("R5 bad opcode", 6'h3F, 6'h20, 10'b0);
    run_one("R5 bad funct",  6'h00, 6'h21, 10'b0);

    // R6 exact timing: ex not visible after one edge, visible after two
    drive(6'h23, 6'h00, 0, 0); step();
    drive(6'h3F, 6'h00, 0, 0);
    o = outs(); check("R6 ex not early", {o[9:4], 4'b0}, 10'b0);
    step(); o = outs(); check("R6 ex on time", {o[9:4], 4'b0}, 10'b0_1_1_000_0000);

    // R7 stall: load held, store ignored, bubble into ex
    drive(6'h23, 6'h00, 0, 0); step();
    drive(6'h2B, 6'h00, 1, 0); step();
    o = outs(); check("R7 stall bubble", {o[9:4], 4'b0}, 10'b0);
    drive(6'h2B, 6'h00, 1, 0); step();
    o = outs(); check("R7 stall bubble 2", {o[9:4], 4'b0}, 10'b0);
    drive(6'h3F, 6'h00, 0, 0); step();
    o = outs(); check("R7 held load resumes", {o[9:4], 4'b0}, 10'b0_1_1_000_0000);
    step();
    o = outs(); check("R7 stalled store ignored", {o[9:4], 4'b0}, 10'b0);
    check("R7 no stray mem write", {9'b0, o[3]}, 10'b0);

    // R8 flush: R-type older survives, load/store squashed
    drive(6'h00, 6'h20, 0, 0); step();
    drive(6'h23, 6'h00, 0, 0); step();
    drive(6'h2B, 6'h00, 1, 1); step();
    o = outs(); check("R8 flush bubble ex", {o[9:4], 4'b0}, 10'b0);
    drive(6'h3F, 6'h00, 0, 0); step();
    o = outs(); check("R8 squashed load", {o[9:4], 4'b0}, 10'b0);
    check("R8 older writes back", {8'b0, o[1:0]}, 10'b01);
    step(); o = outs(); check("R8 squashed no write", {8'b0, o[1:0]}, 10'b0);

    // R6/R7/R8 random mix against the reference model
    for (int i = 0; i < 400; i++) begin
      bit [5:0] op, fn;
      case ($urandom_range(0, 5))
        0: op = 6'h00; 1: op = 6'h23; 2: op = 6'h2B; 3: op = 6'h04;
        4: op = 6'h00; default: op = 6'($urandom);
      endcase
      case ($urandom_range(0, 5))
        0: fn = 6'h20; 1: fn = 6'h22; 2: fn = 6'h24; 3: fn = 6'h25;
        4: fn = 6'h2A; default: fn = 6'($urandom);
      endcase
      drive(op, fn, $urandom_range(0, 4) == 0, $urandom_range(0, 9) == 0);
      step();
      check("R6 random vs model", outs(), model_out());
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule